// File: doc/BRIEF.md
# Runahead Mode Controller

This block governs runahead operation in a simple in-order core. It watches the stream of retiring instructions. When a load at the head of the machine misses in the last-level cache, the block does not let the core stall. It saves a copy of the register values, records the missing address and the load's PC, and switches to runahead mode. In that mode the following instructions keep retiring, but only to discover future memory addresses. A poison (INV) bit for each register tracks which values depend on the outstanding miss. Loads whose address operands are clean send their address out as prefetch requests. Results that are poisoned are reported as dropped.

When the fill for the recorded miss address arrives, the block leaves runahead mode in a single cycle. It copies the saved register values back, clears every poison bit, pulses a restore strobe and presents the PC from which execution restarts. A read port exposes the current value and poison bit of any register, so the surrounding pipeline can use it as its operand source. The pipeline itself, the caches and branch handling are outside this block.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset, runahead_active, restore_pulse, pf_valid and drop_result are 0, and every register reads value 0 with rd_inv 0.
- R2: In normal mode, a retiring instruction with retire_dst_en writes retire_data to its destination, visible at the read port after the next clock edge, and raises neither pf_valid nor drop_result.
- R3: In normal mode, a retiring load with retire_miss set makes runahead_active 1 after the next edge. Its destination becomes INV and keeps its old value, and resume_pc holds that load's retire_pc.
- R4: In runahead mode, an instruction whose source A or source B register is INV gets its destination marked INV, and drop_result is 1 in the cycle after it retires.
- R5: In runahead mode, an instruction with both sources valid and no new miss writes retire_data to its destination, clears that destination's INV bit and leaves drop_result 0.
- R6: In runahead mode, a load with both address sources valid gives pf_valid 1 with pf_addr equal to its retire_addr in the next cycle. A load with an INV address source gives pf_valid 0.
- R7: In runahead mode, a further missing load with valid sources still issues its prefetch, marks its own destination INV and reports drop_result 1. runahead_active stays 1, and the miss address it waits on is unchanged.
- R8: A fill whose address differs from the recorded miss address leaves runahead_active at 1 and causes no restore_pulse.
- R9: A fill matching the recorded miss address in runahead mode gives, after the next edge, runahead_active 0 and restore_pulse 1 for exactly one cycle. Every register holds its value from the moment of entry, and all INV bits are 0.
- R10: An instruction retiring in the same cycle as the matching fill changes no register and issues no prefetch.
- R11: A fill in normal mode has no effect on mode, restore_pulse or register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_pc | input | PC_W | PC of the retiring instruction |
| retire_dst_en | input | 1 | Retiring instruction writes a register |
| retire_dst | input | RIDX_W | Destination register index |
| retire_srca | input | RIDX_W | First source register index |
| retire_srcb | input | RIDX_W | Second source register index |
| retire_is_load | input | 1 | Retiring instruction is a load |
| retire_addr | input | ADDR_W | Load address |
| retire_miss | input | 1 | Load missed in the last-level cache |
| retire_data | input | DATA_W | Result value |
| fill_valid | input | 1 | Memory fill returns this cycle |
| fill_addr | input | ADDR_W | Address of the returning fill |
| rd_idx | input | RIDX_W | Read port register index |
| rd_data | output | DATA_W | Current value of register rd_idx |
| rd_inv | output | 1 | INV bit of register rd_idx |
| runahead_active | output | 1 | Controller is in runahead mode |
| restore_pulse | output | 1 | One-cycle strobe: the saved state was restored |
| resume_pc | output | PC_W | PC of the load that started runahead |
| pf_valid | output | 1 | Prefetch request valid |
| pf_addr | output | ADDR_W | Prefetch request address |
| drop_result | output | 1 | The previous retired result was INV and dropped |

## Verification
The hardest situation to reach is a restore that has to undo a long chain of poisoned and clean speculative writes. The bench gets there by building one runahead episode step by step. It enters on a missing load, then in turn spreads poison, clears it with a clean write, issues prefetches from clean and poisoned address registers, takes a second miss and sends a decoy fill. Only after all of that does it deliver the matching fill together with one more retiring write, so R9 and R10 are checked against register values that were overwritten several times while speculative.

// File: rtl/ra_pkg.sv
package ra_pkg;
  typedef enum logic {
    MODE_NORMAL   = 1'b0,
    MODE_RUNAHEAD = 1'b1
  } ra_mode_e;
endpackage

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm
  import ra_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_valid,
  input  logic              retire_is_load,
  input  logic              retire_miss,
  input  logic [PC_W-1:0]   retire_pc,
  input  logic [ADDR_W-1:0] retire_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              mode_q,
  output logic              enter_evt,
  output logic              exit_evt,
  output logic [ADDR_W-1:0] miss_addr_q,
  output logic [PC_W-1:0]   resume_pc_q,
  output logic              restore_q
);
  ra_mode_e state_q, state_d;

  function automatic logic fill_matches(input logic v, input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] want);
    return v && (a == want);
  endfunction

  assign enter_evt = (state_q == MODE_NORMAL) && retire_valid && retire_is_load && retire_miss;
  assign exit_evt  = (state_q == MODE_RUNAHEAD) && fill_matches(fill_valid, fill_addr, miss_addr_q);

  always_comb begin
    state_d = state_q;
    if (enter_evt)     state_d = MODE_RUNAHEAD;
    else if (exit_evt) state_d = MODE_NORMAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= MODE_NORMAL;
      miss_addr_q <= '0;
      resume_pc_q <= '0;
      restore_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      restore_q <= exit_evt;
      if (enter_evt) begin
        miss_addr_q <= retire_addr;
        resume_pc_q <= retire_pc;
      end
    end
  end

  assign mode_q = (state_q == MODE_RUNAHEAD);
endmodule

// File: rtl/ra_inv_track.sv
module ra_inv_track #(
  parameter int NREG   = 8,
  parameter int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              enter_evt,
  input  logic              exit_evt,
  input  logic              retire_valid,
  input  logic              retire_dst_en,
  input  logic [RIDX_W-1:0] retire_dst,
  input  logic [RIDX_W-1:0] retire_srca,
  input  logic [RIDX_W-1:0] retire_srcb,
  input  logic              retire_is_load,
  input  logic              retire_miss,
  input  logic [RIDX_W-1:0] rd_idx,
  output logic [NREG-1:0]   inv_vec,
  output logic              src_poison,
  output logic              result_inv,
  output logic              rd_inv
);
  logic [NREG-1:0] inv_q;
  logic            ra_write;

  function automatic logic any_poisoned(input logic [NREG-1:0] v,
                                        input logic [RIDX_W-1:0] a,
                                        input logic [RIDX_W-1:0] b);
    return v[a] | v[b];
  endfunction

  function automatic logic [NREG-1:0] onehot(input logic [RIDX_W-1:0] i);
    logic [NREG-1:0] r;
    r = '0;
    r[i] = 1'b1;
    return r;
  endfunction

  assign src_poison = any_poisoned(inv_q, retire_srca, retire_srcb);
  assign result_inv = src_poison | (retire_is_load & retire_miss);
  assign ra_write   = mode && retire_valid && retire_dst_en && !exit_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q <= '0;
    end else if (exit_evt) begin
      inv_q <= '0;
    end else if (enter_evt) begin
      inv_q <= retire_dst_en ? onehot(retire_dst) : '0;
    end else if (ra_write) begin
      if (result_inv) inv_q <= inv_q | onehot(retire_dst);
      else            inv_q <= inv_q & ~onehot(retire_dst);
    end
  end

  assign inv_vec = inv_q;
  assign rd_inv  = inv_q[rd_idx];
endmodule

// File: rtl/ra_regfile.sv
module ra_regfile #(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  parameter int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_evt,
  input  logic              exit_evt,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [RIDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] work_view [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] work_q;
    logic [DATA_W-1:0] ckpt_q;
    logic              hit;

    assign hit = wr_en && (wr_idx == RIDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        work_q <= '0;
        ckpt_q <= '0;
      end else if (exit_evt) begin
        work_q <= ckpt_q;
      end else begin
        if (enter_evt) ckpt_q <= work_q;
        if (hit)       work_q <= wr_data;
      end
    end

    assign work_view[g] = work_q;
  end

  assign rd_data = work_view[rd_idx];
endmodule

// File: rtl/ra_issue.sv
module ra_issue #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              exit_evt,
  input  logic              retire_valid,
  input  logic              retire_is_load,
  input  logic [ADDR_W-1:0] retire_addr,
  input  logic              src_poison,
  input  logic              result_inv,
  output logic              pf_valid_q,
  output logic [ADDR_W-1:0] pf_addr_q,
  output logic              drop_q
);
  logic spec_retire;
  assign spec_retire = mode && retire_valid && !exit_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid_q <= 1'b0;
      pf_addr_q  <= '0;
      drop_q     <= 1'b0;
    end else begin
      pf_valid_q <= spec_retire && retire_is_load && !src_poison;
      drop_q     <= spec_retire && result_inv;
      if (spec_retire && retire_is_load && !src_poison) pf_addr_q <= retire_addr;
    end
  end
endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl #(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int PC_W   = 16,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_valid,
  input  logic [PC_W-1:0]   retire_pc,
  input  logic              retire_dst_en,
  input  logic [RIDX_W-1:0] retire_dst,
  input  logic [RIDX_W-1:0] retire_srca,
  input  logic [RIDX_W-1:0] retire_srcb,
  input  logic              retire_is_load,
  input  logic [ADDR_W-1:0] retire_addr,
  input  logic              retire_miss,
  input  logic [DATA_W-1:0] retire_data,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [RIDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_inv,
  output logic              runahead_active,
  output logic              restore_pulse,
  output logic [PC_W-1:0]   resume_pc,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              drop_result
);
  logic              mode_q, enter_evt, exit_evt, restore_q;
  logic [ADDR_W-1:0] miss_addr_q;
  logic [NREG-1:0]   inv_vec;
  logic              src_poison, result_inv, wr_en;

  ra_mode_fsm #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid),
    .retire_is_load(retire_is_load), .retire_miss(retire_miss),
    .retire_pc(retire_pc), .retire_addr(retire_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .mode_q(mode_q), .enter_evt(enter_evt), .exit_evt(exit_evt),
    .miss_addr_q(miss_addr_q), .resume_pc_q(resume_pc), .restore_q(restore_q)
  );

  ra_inv_track #(.NREG(NREG)) u_inv (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .enter_evt(enter_evt),
    .exit_evt(exit_evt), .retire_valid(retire_valid),
    .retire_dst_en(retire_dst_en), .retire_dst(retire_dst),
    .retire_srca(retire_srca), .retire_srcb(retire_srcb),
    .retire_is_load(retire_is_load), .retire_miss(retire_miss),
    .rd_idx(rd_idx), .inv_vec(inv_vec), .src_poison(src_poison),
    .result_inv(result_inv), .rd_inv(rd_inv)
  );

  // Normal mode: every write except the missing load's. Runahead: clean results only.
  always_comb begin
    wr_en = 1'b0;
    if (retire_valid && retire_dst_en && !exit_evt) begin
      if (mode_q) wr_en = !result_inv;
      else        wr_en = !(retire_is_load && retire_miss);
    end
  end

  ra_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .enter_evt(enter_evt), .exit_evt(exit_evt),
    .wr_en(wr_en), .wr_idx(retire_dst), .wr_data(retire_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  ra_issue #(.ADDR_W(ADDR_W)) u_iss (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .exit_evt(exit_evt),
    .retire_valid(retire_valid), .retire_is_load(retire_is_load),
    .retire_addr(retire_addr), .src_poison(src_poison),
    .result_inv(result_inv), .pf_valid_q(pf_valid), .pf_addr_q(pf_addr),
    .drop_q(drop_result)
  );

  assign runahead_active = mode_q;
  assign restore_pulse   = restore_q;
endmodule

// File: rtl/runahead_ctrl_checker.sv
module runahead_ctrl_checker #(
  parameter int NREG   = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_q,
  input logic              restore_q,
  input logic              pf_valid,
  input logic              drop_result,
  input logic [NREG-1:0]   inv_vec,
  input logic [ADDR_W-1:0] miss_addr_q,
  input logic              retire_valid,
  input logic              retire_is_load,
  input logic              retire_miss,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_addr
);
  assert_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && retire_valid && retire_is_load && retire_miss) |=> mode_q);

  assert_drop_in_runahead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_result |-> $past(mode_q));

  assert_pf_in_runahead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(mode_q));

  assert_further_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && retire_valid && retire_is_load && retire_miss &&
     !(fill_valid && fill_addr == miss_addr_q)) |=> (mode_q && $stable(miss_addr_q)));

  assert_other_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && fill_valid && fill_addr != miss_addr_q) |=> mode_q);

  assert_restore_on_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restore_q |-> (!mode_q && $past(mode_q)));

  assert_inv_clear_normal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (inv_vec == '0));

  assert_normal_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !(retire_valid && retire_is_load && retire_miss)) |=> (!mode_q && !restore_q));
endmodule

bind runahead_ctrl runahead_ctrl_checker #(.NREG(NREG), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .restore_q(restore_q),
  .pf_valid(pf_valid), .drop_result(drop_result), .inv_vec(inv_vec),
  .miss_addr_q(miss_addr_q), .retire_valid(retire_valid),
  .retire_is_load(retire_is_load), .retire_miss(retire_miss),
  .fill_valid(fill_valid), .fill_addr(fill_addr)
);

// File: tb/runahead_ctrl_test.sv
`timescale 1ns/1ps
module runahead_ctrl_test;
  localparam int NREG = 8, DW = 16, AW = 16, PW = 16, RW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic retire_valid = 0, retire_dst_en = 0, retire_is_load = 0, retire_miss = 0;
  logic [PW-1:0] retire_pc = '0;
  logic [RW-1:0] retire_dst = '0, retire_srca = '0, retire_srcb = '0, rd_idx = '0;
  logic [AW-1:0] retire_addr = '0, fill_addr = '0;
  logic [DW-1:0] retire_data = '0;
  logic fill_valid = 0;
  logic [DW-1:0] rd_data;
  logic rd_inv, runahead_active, restore_pulse, pf_valid, drop_result;
  logic [PW-1:0] resume_pc;
  logic [AW-1:0] pf_addr;

  int checks = 0, errors = 0;
  logic s_pf, s_drop;
  logic [AW-1:0] s_pfa;
  logic [DW-1:0] model [NREG];

  always #2.5 clk = ~clk;

  runahead_ctrl uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_reg(input int r, output logic [DW-1:0] d, output logic inv);
    rd_idx = RW'(r);
    #0.1;
    d = rd_data;
    inv = rd_inv;
  endtask

  task automatic check_reg(input string req, input int r, input logic [DW-1:0] d, input logic inv);
    logic [DW-1:0] ad;
    logic ai;
    read_reg(r, ad, ai);
    chk({req, " value"}, 32'(ad), 32'(d));
    chk({req, " inv"}, 32'(ai), 32'(inv));
  endtask

  task automatic drive(input int pc, input int dst, input int a, input int b,
                       input logic ld, input int addr, input logic miss, input int data);
    retire_valid = 1; retire_pc = PW'(pc); retire_dst_en = 1; retire_dst = RW'(dst);
    retire_srca = RW'(a); retire_srcb = RW'(b); retire_is_load = ld;
    retire_addr = AW'(addr); retire_miss = miss; retire_data = DW'(data);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    s_pf = pf_valid; s_pfa = pf_addr; s_drop = drop_result;
    retire_valid = 0; retire_miss = 0; fill_valid = 0;
  endtask

  task automatic retire(input int pc, input int dst, input int a, input int b,
                        input logic ld, input int addr, input logic miss, input int data);
    drive(pc, dst, a, b, ld, addr, miss, data);
    step();
  endtask

  task automatic fill(input int addr);
    fill_valid = 1; fill_addr = AW'(addr);
    step();
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(runahead_active), 0);
    chk("R1 restore", 32'(restore_pulse), 0);
    chk("R1 pf", 32'(pf_valid), 0);
    chk("R1 drop", 32'(drop_result), 0);
    for (int r = 0; r < NREG; r++) check_reg("R1 reg", r, '0, 1'b0);
  endtask

  task automatic t_normal();
    for (int r = 1; r <= 4; r++) begin
      retire(16 + r, r, 0, 0, 0, 0, 0, r * 17);
      model[r] = DW'(r * 17);
      chk("R2 pf", 32'(s_pf), 0);
      chk("R2 drop", 32'(s_drop), 0);
    end
    retire(32, 5, 1, 2, 1, 'h100, 0, 'h55);
    model[5] = 16'h55;
    chk("R2 load hit pf", 32'(s_pf), 0);
    for (int r = 0; r < NREG; r++) check_reg("R2 reg", r, model[r], 1'b0);
    chk("R2 mode", 32'(runahead_active), 0);
  endtask

  task automatic t_enter();
    retire('h40, 6, 1, 1, 1, 'h2000, 1, 'hDEAD);
    chk("R3 mode", 32'(runahead_active), 1);
    chk("R3 resume_pc", 32'(resume_pc), 32'h40);
    chk("R3 no pf", 32'(s_pf), 0);
    check_reg("R3 dst", 6, model[6], 1'b1);
  endtask

  task automatic t_spread();
    retire('h44, 7, 6, 2, 0, 0, 0, 'h77);
    chk("R4 drop", 32'(s_drop), 1);
    check_reg("R4 dst", 7, 16'h0, 1'b1);
    retire('h48, 3, 7, 7, 1, 'h3000, 0, 'h3333);
    chk("R6 inv-addr no pf", 32'(s_pf), 0);
    chk("R4 load drop", 32'(s_drop), 1);
    check_reg("R4 load dst", 3, model[3], 1'b1);
  endtask

  task automatic t_clean();
    retire('h4C, 7, 1, 2, 0, 0, 0, 'h99);
    chk("R5 drop", 32'(s_drop), 0);
    check_reg("R5 dst", 7, 16'h99, 1'b0);
    retire('h50, 2, 1, 1, 1, 'h4000, 0, 'hAB);
    chk("R6 pf", 32'(s_pf), 1);
    chk("R6 pf addr", 32'(s_pfa), 32'h4000);
    chk("R5 load drop", 32'(s_drop), 0);
    check_reg("R5 load dst", 2, 16'hAB, 1'b0);
  endtask

  task automatic t_further_miss();
    retire('h54, 4, 1, 2, 1, 'h5000, 1, 'h1111);
    chk("R7 pf", 32'(s_pf), 1);
    chk("R7 pf addr", 32'(s_pfa), 32'h5000);
    chk("R7 drop", 32'(s_drop), 1);
    chk("R7 mode", 32'(runahead_active), 1);
    check_reg("R7 dst", 4, model[4], 1'b1);
  endtask

  task automatic t_other_fill();
    fill('h5000);
    chk("R8 mode after further-miss fill", 32'(runahead_active), 1);
    chk("R8 restore", 32'(restore_pulse), 0);
    fill('h1234);
    chk("R8 mode after stray fill", 32'(runahead_active), 1);
    check_reg("R8 state kept", 2, 16'hAB, 1'b0);
  endtask

  task automatic t_exit();
    fill_valid = 1; fill_addr = 16'h2000;
    drive('h58, 1, 1, 1, 1, 'h6000, 0, 'hEE);
    step();
    chk("R9 mode", 32'(runahead_active), 0);
    chk("R9 restore", 32'(restore_pulse), 1);
    chk("R10 no pf", 32'(s_pf), 0);
    chk("R9 resume_pc", 32'(resume_pc), 32'h40);
    for (int r = 0; r < NREG; r++) check_reg("R9/R10 reg", r, model[r], 1'b0);
    step();
    chk("R9 restore one cycle", 32'(restore_pulse), 0);
  endtask

  task automatic t_normal_fill();
    fill('h2000);
    chk("R11 mode", 32'(runahead_active), 0);
    chk("R11 restore", 32'(restore_pulse), 0);
    check_reg("R11 reg", 1, model[1], 1'b0);
    retire('h60, 6, 1, 2, 0, 0, 0, 'h66);
    model[6] = 16'h66;
    check_reg("R2 resume write", 6, 16'h66, 1'b0);
  endtask

  initial begin
    for (int r = 0; r < NREG; r++) model[r] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_normal();
    t_enter();
    t_spread();
    t_clean();
    t_further_miss();
    t_other_fill();
    t_exit();
    t_normal_fill();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule